// File: doc/BRIEF.md
# Programmable Video Raster Timing Generator

This block turns a programmable modeline into raster timing for a video output path. A horizontal dot counter and a vertical line counter sweep the full line and frame (or field) lengths. Horizontal sync, vertical sync, a visible-area enable, a pixel strobe and a frame-start pulse are decoded from those counters. Progressive and interlaced output are both supported. In interlaced mode a field bit alternates between fields. On the odd field, the vertical sync edges move from dot 0 to a programmable halfline dot.

A pixel-repetition mode holds every dot for two clocks. This lets the dot clock run at twice the pixel rate, and the pixel strobe marks the first clock of each pair. The synchronous active-low reset is meant to be pulsed each time any modeline value is rewritten.

After the reset is released, a small sequencer spends one clock in `ST_IDLE` with all outputs quiet. It then moves to `ST_DOT_A`, the first clock of each dot. When repetition is off it stays in `ST_DOT_A`, and the counters advance on every clock. When repetition is on it alternates with `ST_DOT_B`, the second clock of a dot, and the counters advance only when leaving `ST_DOT_B`. The named transitions are:

- `IDLE->DOT_A`, which is always taken.
- `DOT_A->DOT_A`, taken when repetition is off.
- `DOT_A->DOT_B`, taken when repetition is on.
- `DOT_B->DOT_A`, which is always taken.

Top module: `vid_raster_gen`

## Requirements
- R1: While `rst_n` is low, and during the one clock after it is released, `pix_x`=0, `pix_y`=0 and `field_odd`=0. In that same window `pix_stb`, `vis_en`, `hsync`, `vsync` and `frame_start` are all 0. Dot (0,0) is presented after the first rising edge with `rst_n` high.
- R2: `pix_x` advances by one per dot, from 0 up to `h_total`-1, and then wraps to 0.
- R3: `pix_y` advances by one each time `pix_x` wraps, from 0 up to `v_total`-1, and then wraps to 0.
- R4: `hsync` is high exactly when `h_sync_on` <= `pix_x` < `h_sync_off`.
- R5: In progressive mode, `vsync` rises at position (line `v_sync_on`, dot 0). It stays high up to, but not including, position (line `v_sync_off`, dot 0), with positions ordered line first and then dot.
- R6: With `interlace_en`=1, `field_odd` toggles each time `pix_y` wraps. With `interlace_en`=0, `field_odd` stays 0.
- R7: In interlaced mode with `field_odd`=1, both vertical sync edges use dot `v_half_dot` in place of dot 0. With `field_odd`=0 they use dot 0.
- R8: With `interlace_en`=0, the value of `v_half_dot` has no effect on any output.
- R9: `vis_en` is high exactly when `pix_x` <= `h_active_last` and `pix_y` <= `v_active_last`.
- R10: With `pix_rep_en`=1, each dot lasts two clocks and `pix_stb` is high on the first clock of each dot only. With `pix_rep_en`=0, `pix_stb` is high on every running clock.
- R11: `frame_start` is high on the `pix_stb` clock of dot (0,0) of every frame or field, and at no other time.
- R12: Pulsing `rst_n` in the middle of a frame restarts the raster from the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset, pulsed on modeline rewrite |
| h_active_last | input | 12 | Last visible dot of a line (visible dots minus one) |
| h_sync_on | input | 12 | Dot where horizontal sync starts |
| h_sync_off | input | 12 | Dot where horizontal sync stops (exclusive) |
| h_total | input | 12 | Dots per line |
| v_active_last | input | 12 | Last visible line (visible lines minus one) |
| v_sync_on | input | 12 | Line where vertical sync starts |
| v_sync_off | input | 12 | Line where vertical sync stops (exclusive) |
| v_total | input | 12 | Lines per frame (progressive) or per field (interlaced) |
| v_half_dot | input | 12 | Vertical sync edge dot on odd fields |
| interlace_en | input | 1 | 1 = interlaced output |
| pix_rep_en | input | 1 | 1 = each dot held for two clocks |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| vis_en | output | 1 | Visible-area enable |
| pix_x | output | 12 | Current dot |
| pix_y | output | 12 | Current line |
| field_odd | output | 1 | Field bit, 1 on odd field |
| pix_stb | output | 1 | First clock of each dot |
| frame_start | output | 1 | Dot (0,0) strobe |

## Verification
Every output is decoded combinationally from registered counters and the sequencer state. The outputs for running clock index m are therefore valid after rising edge m+1 following reset release, and the quiet idle state is visible before that first edge. Running clock index m maps to dot m when repetition is off, and to dot m/2 when it is on. The bench samples on falling edges, derives the expected dot, line and field from m and the programmed modeline, and compares every output on every clock. It also checks the idle clock after each reset, including a reset issued in the middle of a frame.

// File: rtl/vrg_pkg.sv
package vrg_pkg;
    localparam int CNT_W = 12;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DOT_A = 2'd1,
        ST_DOT_B = 2'd2
    } vrg_state_e;
endpackage

// File: rtl/vrg_seq.sv
module vrg_seq
    import vrg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rep_en,
    output vrg_state_e state_o,
    output logic       adv_o,
    output logic       stb_o,
    output logic       run_o
);
    vrg_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_DOT_A;
            ST_DOT_A: state_d = rep_en ? ST_DOT_B : ST_DOT_A;
            ST_DOT_B: state_d = ST_DOT_A;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        adv_o = 1'b0;
        stb_o = 1'b0;
        run_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                adv_o = 1'b0;
                stb_o = 1'b0;
                run_o = 1'b0;
            end
            ST_DOT_A: begin
                adv_o = !rep_en;
                stb_o = 1'b1;
                run_o = 1'b1;
            end
            ST_DOT_B: begin
                adv_o = 1'b1;
                stb_o = 1'b0;
                run_o = 1'b1;
            end
            default: begin
                adv_o = 1'b0;
                stb_o = 1'b0;
                run_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

    // R10
    dot_b_follows_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOT_B) |-> ($past(state_q) == ST_DOT_A));

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (state_q == ST_IDLE));
endmodule

// File: rtl/vrg_hcount.sv
module vrg_hcount #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [CW-1:0] h_total,
    output logic [CW-1:0] x_o,
    output logic          line_end_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] x_q;

    assign line_end_o = (x_q >= (h_total - ONE));

    always_ff @(posedge clk) begin
        if (!rst_n)        x_q <= '0;
        else if (adv) begin
            if (line_end_o) x_q <= '0;
            else            x_q <= x_q + ONE;
        end
    end

    assign x_o = x_q;

    // R2
    x_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_total != '0) |-> (x_q < h_total));

    // R2
    x_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(x_q));
endmodule

// File: rtl/vrg_vcount.sv
module vrg_vcount #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          line_end,
    input  logic [CW-1:0] v_total,
    input  logic          interlace_en,
    output logic [CW-1:0] y_o,
    output logic          field_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] y_q;
    logic          field_q;
    logic          frame_end;

    assign frame_end = (y_q >= (v_total - ONE));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q     <= '0;
            field_q <= 1'b0;
        end else begin
            if (adv && line_end) begin
                if (frame_end) y_q <= '0;
                else           y_q <= y_q + ONE;
            end
            if (!interlace_en)                    field_q <= 1'b0;
            else if (adv && line_end && frame_end) field_q <= !field_q;
        end
    end

    assign y_o     = y_q;
    assign field_o = field_q;

    // R3
    y_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_total != '0) |-> (y_q < v_total));

    // R6
    field_zero_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !interlace_en |=> !field_q);
endmodule

// File: rtl/vrg_decode.sv
module vrg_decode #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          stb,
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    input  logic          field,
    input  logic          interlace_en,
    input  logic [CW-1:0] h_active_last,
    input  logic [CW-1:0] h_sync_on,
    input  logic [CW-1:0] h_sync_off,
    input  logic [CW-1:0] v_active_last,
    input  logic [CW-1:0] v_sync_on,
    input  logic [CW-1:0] v_sync_off,
    input  logic [CW-1:0] v_half_dot,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          vis_o,
    output logic          frame_start_o
);
    logic [CW-1:0] edge_dot;
    logic          past_on;
    logic          before_off;

    always_comb begin
        edge_dot      = (interlace_en && field) ? v_half_dot : '0;
        past_on       = (y > v_sync_on) || ((y == v_sync_on) && (x >= edge_dot));
        before_off    = (y < v_sync_off) || ((y == v_sync_off) && (x < edge_dot));
        hsync_o       = run && (x >= h_sync_on) && (x < h_sync_off);
        vsync_o       = run && past_on && before_off;
        vis_o         = run && (x <= h_active_last) && (y <= v_active_last);
        frame_start_o = stb && (x == '0) && (y == '0);
    end

    // R11
    frame_start_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> (stb && run));

    // R1
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !(hsync_o || vsync_o || vis_o || frame_start_o));
endmodule

// File: rtl/vid_raster_gen.sv
module vid_raster_gen
    import vrg_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] h_active_last,
    input  logic [CW-1:0] h_sync_on,
    input  logic [CW-1:0] h_sync_off,
    input  logic [CW-1:0] h_total,
    input  logic [CW-1:0] v_active_last,
    input  logic [CW-1:0] v_sync_on,
    input  logic [CW-1:0] v_sync_off,
    input  logic [CW-1:0] v_total,
    input  logic [CW-1:0] v_half_dot,
    input  logic          interlace_en,
    input  logic          pix_rep_en,
    output logic          hsync,
    output logic          vsync,
    output logic          vis_en,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] pix_y,
    output logic          field_odd,
    output logic          pix_stb,
    output logic          frame_start
);
    vrg_state_e    state;
    logic          adv;
    logic          stb;
    logic          run;
    logic          line_end;
    logic [CW-1:0] x;
    logic [CW-1:0] y;
    logic          field;

    vrg_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rep_en  (pix_rep_en),
        .state_o (state),
        .adv_o   (adv),
        .stb_o   (stb),
        .run_o   (run)
    );

    vrg_hcount #(.CW(CW)) u_hcnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .h_total    (h_total),
        .x_o        (x),
        .line_end_o (line_end)
    );

    vrg_vcount #(.CW(CW)) u_vcnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv          (adv),
        .line_end     (line_end),
        .v_total      (v_total),
        .interlace_en (interlace_en),
        .y_o          (y),
        .field_o      (field)
    );

    vrg_decode #(.CW(CW)) u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .stb           (stb),
        .x             (x),
        .y             (y),
        .field         (field),
        .interlace_en  (interlace_en),
        .h_active_last (h_active_last),
        .h_sync_on     (h_sync_on),
        .h_sync_off    (h_sync_off),
        .v_active_last (v_active_last),
        .v_sync_on     (v_sync_on),
        .v_sync_off    (v_sync_off),
        .v_half_dot    (v_half_dot),
        .hsync_o       (hsync),
        .vsync_o       (vsync),
        .vis_o         (vis_en),
        .frame_start_o (frame_start)
    );

    assign pix_x     = x;
    assign pix_y     = y;
    assign field_odd = field;
    assign pix_stb   = stb;

    // R10
    stb_only_on_dot_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |-> (state == ST_DOT_A));
endmodule

// File: tb/vid_raster_gen_bench.sv
module vid_raster_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] h_active_last = 12'd5, h_sync_on = 12'd7, h_sync_off = 12'd9, h_total = 12'd10;
    logic [11:0] v_active_last = 12'd3, v_sync_on = 12'd4, v_sync_off = 12'd5, v_total = 12'd6;
    logic [11:0] v_half_dot = 12'd5;
    logic        interlace_en = 1'b0, pix_rep_en = 1'b0;
    logic        hsync, vsync, vis_en, field_odd, pix_stb, frame_start;
    logic [11:0] pix_x, pix_y;
    int checks = 0;
    int errors = 0;

    always #2 clk = !clk;

    vid_raster_gen u_vid_raster_gen (
        .clk(clk), .rst_n(rst_n),
        .h_active_last(h_active_last), .h_sync_on(h_sync_on), .h_sync_off(h_sync_off), .h_total(h_total),
        .v_active_last(v_active_last), .v_sync_on(v_sync_on), .v_sync_off(v_sync_off), .v_total(v_total),
        .v_half_dot(v_half_dot), .interlace_en(interlace_en), .pix_rep_en(pix_rep_en),
        .hsync(hsync), .vsync(vsync), .vis_en(vis_en), .pix_x(pix_x), .pix_y(pix_y),
        .field_odd(field_odd), .pix_stb(pix_stb), .frame_start(frame_start)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // R1: apply reset, release it and check the quiet idle clock before the first running edge
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "x in reset", int'(pix_x), 0);
        rst_n = 1'b1;
        #0.5;
        chk("R1", "x idle", int'(pix_x), 0);
        chk("R1", "y idle", int'(pix_y), 0);
        chk("R1", "field idle", int'(field_odd), 0);
        chk("R1", "stb idle", int'(pix_stb), 0);
        chk("R1", "vis idle", int'(vis_en), 0);
        chk("R1", "hsync idle", int'(hsync), 0);
        chk("R1", "vsync idle", int'(vsync), 0);
        chk("R1", "frame idle", int'(frame_start), 0);
    endtask

    // compare every output for running clocks 0..n-1 against values derived from the modeline
    task automatic run_check(input int n);
        for (int m = 0; m < n; m++) begin
            int dot, ex, ey, fld, sd, hs, vs, vis, stb, fs;
            @(negedge clk);
            dot = pix_rep_en ? m / 2 : m;
            ex  = dot % int'(h_total);
            ey  = (dot / int'(h_total)) % int'(v_total);
            fld = interlace_en ? (dot / (int'(h_total) * int'(v_total))) % 2 : 0;
            sd  = (interlace_en && fld == 1) ? int'(v_half_dot) : 0;
            hs  = (ex >= int'(h_sync_on) && ex < int'(h_sync_off)) ? 1 : 0;
            vs  = ((ey > int'(v_sync_on) || (ey == int'(v_sync_on) && ex >= sd)) &&
                   (ey < int'(v_sync_off) || (ey == int'(v_sync_off) && ex < sd))) ? 1 : 0;
            vis = (ex <= int'(h_active_last) && ey <= int'(v_active_last)) ? 1 : 0;
            stb = pix_rep_en ? ((m % 2 == 0) ? 1 : 0) : 1;
            fs  = (stb == 1 && ex == 0 && ey == 0) ? 1 : 0;
            chk("R2", "pix_x", int'(pix_x), ex);
            chk("R3", "pix_y", int'(pix_y), ey);
            chk("R6", "field_odd", int'(field_odd), fld);
            chk("R4", "hsync", int'(hsync), hs);
            chk(interlace_en ? "R7" : "R5", "vsync", int'(vsync), vs);
            chk("R9", "vis_en", int'(vis_en), vis);
            chk("R10", "pix_stb", int'(pix_stb), stb);
            chk("R11", "frame_start", int'(frame_start), fs);
        end
    endtask

    task automatic t_progressive();
        interlace_en = 1'b0; pix_rep_en = 1'b0; v_half_dot = 12'd5;
        do_reset();
        run_check(130);
    endtask

    // R8: a different halfline value in progressive mode must leave vsync timing unchanged
    task automatic t_halfline_ignored();
        interlace_en = 1'b0; pix_rep_en = 1'b0; v_half_dot = 12'd3;
        do_reset();
        run_check(70);
        chk("R8", "field stays even", int'(field_odd), 0);
    endtask

    task automatic t_interlaced();
        interlace_en = 1'b1; pix_rep_en = 1'b0; v_half_dot = 12'd5;
        do_reset();
        run_check(250);
    endtask

    task automatic t_repeat();
        interlace_en = 1'b0; pix_rep_en = 1'b1;
        do_reset();
        run_check(140);
    endtask

    // R12: reset in the middle of a frame restarts the raster
    task automatic t_midframe_reset();
        interlace_en = 1'b1; pix_rep_en = 1'b0;
        do_reset();
        run_check(37);
        chk("R12", "mid-frame x before reset", int'(pix_x), 6);
        h_total = 12'd12; h_sync_on = 12'd8; h_sync_off = 12'd11;
        do_reset();
        run_check(160);
    endtask

    initial begin
        t_progressive();
        t_halfline_ignored();
        t_interlaced();
        t_repeat();
        t_midframe_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule